// File: doc/BRIEF.md
# Gated Serial Byte Receiver

This block takes an asynchronous serial line, idle high, and turns each framed byte into one steady 8-bit parallel word. A typical load is one column pattern of an LED dot matrix. A line that is driven from outside is first passed through a two-flop synchronizer.

A falling edge after an idle period marks a possible start bit. A divider clocked by the faster system clock waits half a bit time and checks the line again. If the line is low, a burst of exactly eight bit-centre sampling strobes follows, and then the burst stops. Each strobe shifts one data bit into a shift register.

One bit time after the last data bit, the stop bit is sampled. It is checked but never shifted in. If it is high, a holding register takes the assembled byte and a one-cycle valid strobe is raised. If it is low, a one-cycle framing-error flag is raised and the holding register keeps its old value. Downstream logic therefore only ever sees complete bytes.

Top module: `serial_byte_rx`

## Requirements
- R1: While synchronous active-high reset is applied, and in the first cycle after it, dataOut is 0x00, byteValid is 0 and frameError is 0.
- R2: Data bits are received least significant first. After a frame, dataOut[0] holds the first data bit and dataOut[7] holds the last one, so a transmitted value of 1011_0110 reads back as 1011_0110.
- R3: Only a high-to-low transition of the synchronized line begins a frame. A line that stays low after a frame does not start another frame until it has gone high and then falls again.
- R4: A low pulse shorter than half a bit time, which is back high at the half-bit recheck, is ignored. It produces no byteValid and no frameError, and dataOut is unchanged.
- R5: Each accepted frame shifts exactly eight data bits, and the stop bit is never shifted in. For example, a byte of 0x00 with a high stop bit reads back as 0x00.
- R6: dataOut changes only in a cycle where byteValid is high. It never shows a partly filled shift register.
- R7: byteValid is high for exactly one system clock per good frame. That is the cycle in which dataOut first shows the new byte.
- R8: A stop bit sampled low raises frameError for exactly one system clock. byteValid stays low and dataOut keeps its previous value.
- R9: Frames sent back to back, with only a single stop bit between them, are each received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, CLKS_PER_BIT cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| serialIn | input | 1 | Asynchronous serial line, idle high |
| dataOut | output | DATA_BITS | Last complete byte received |
| byteValid | output | 1 | One-cycle strobe when dataOut loads |
| frameError | output | 1 | One-cycle strobe when the stop bit is low |

## Verification
The hardest states to reach from the ports are the ones where the line does something other than a clean frame. One case is a short low glitch that must be dropped at the half-bit recheck. Another is a line that stays low after a bad stop bit and must not be taken as a new start.

The bench drives the line directly, cycle by cycle. It makes a three-cycle low pulse, and it makes a frame whose stop bit is low and then holds the line low for several bit times before releasing it. A byte of 0x00 exposes a ninth shift, because a shifted-in stop bit would show up as 0x80. A monitor running on every falling clock edge flags any change of dataOut that arrives without byteValid.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef struct packed {
    logic shift;
    logic load;
    logic frameErr;
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_BITS    = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lineLevel,
  input  logic      lineFell,
  output rxStrobe_t strobes
);
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_TICK = CW'(CLKS_PER_BIT / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_BITS - 1);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} rxState_t;

  rxState_t      state;
  logic [CW-1:0] baudCnt;
  logic [BW-1:0] bitCnt;
  logic          tickEnd;

  assign tickEnd = (baudCnt == LAST_TICK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= IDLE;
      baudCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        IDLE: begin
          baudCnt <= '0;
          bitCnt  <= '0;
          if (lineFell) state <= START;
        end
        START: begin
          if (baudCnt == HALF_TICK) begin
            baudCnt <= '0;
            state   <= lineLevel ? IDLE : DATA;
          end else begin
            baudCnt <= baudCnt + 1'b1;
          end
        end
        DATA: begin
          if (tickEnd) begin
            baudCnt <= '0;
            bitCnt  <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) state <= STOP;
          end else begin
            baudCnt <= baudCnt + 1'b1;
          end
        end
        STOP: begin
          if (tickEnd) begin
            baudCnt <= '0;
            state   <= IDLE;
          end else begin
            baudCnt <= baudCnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.shift    = (state == DATA) && tickEnd;
    strobes.load     = (state == STOP) && tickEnd && lineLevel;
    strobes.frameErr = (state == STOP) && tickEnd && !lineLevel;
  end
endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serialIn,
  input  rxStrobe_t            strobes,
  output logic                 lineLevel,
  output logic                 lineFell,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 byteValid,
  output logic                 frameError
);
  logic                 syncA, syncB, syncPrev;
  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA    <= 1'b1;
      syncB    <= 1'b1;
      syncPrev <= 1'b1;
    end else begin
      syncA    <= serialIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign lineLevel = syncB;
  assign lineFell  = syncPrev & ~syncB;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg   <= '0;
      dataOut    <= '0;
      byteValid  <= 1'b0;
      frameError <= 1'b0;
    end else begin
      if (strobes.shift) shiftReg <= {syncB, shiftReg[DATA_BITS-1:1]};
      if (strobes.load)  dataOut  <= shiftReg;
      byteValid  <= strobes.load;
      frameError <= strobes.frameErr;
    end
  end
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx
  import serial_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int DATA_BITS    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serialIn,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 byteValid,
  output logic                 frameError
);
  rxStrobe_t strobes;
  logic      lineLevel;
  logic      lineFell;

  serial_rx_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(DATA_BITS)) ctrl (
    .clk(clk), .rst(rst), .lineLevel(lineLevel), .lineFell(lineFell),
    .strobes(strobes)
  );

  serial_rx_datapath #(.DATA_BITS(DATA_BITS)) dpath (
    .clk(clk), .rst(rst), .serialIn(serialIn), .strobes(strobes),
    .lineLevel(lineLevel), .lineFell(lineFell), .dataOut(dataOut),
    .byteValid(byteValid), .frameError(frameError)
  );
endmodule

// File: rtl/serial_byte_rx_chk.sv
module serial_byte_rx_chk
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_BITS-1:0] dataOut,
  input logic                 byteValid,
  input logic                 frameError,
  input rxStrobe_t            strobes
);
  logic [7:0] shiftCnt;

  always_ff @(posedge clk) begin
    if (rst) shiftCnt <= '0;
    else if (strobes.load || strobes.frameErr) shiftCnt <= '0;
    else if (strobes.shift) shiftCnt <= shiftCnt + 1'b1;
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byteValid |=> !byteValid);

  // R8
  ferr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    frameError |=> !frameError);

  // R8
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(byteValid && frameError));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !byteValid |-> $stable(dataOut));

  // R5
  eight_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load || strobes.frameErr) |-> (shiftCnt == 8'(DATA_BITS)));

  // R5
  shift_bound_chk: assert property (@(posedge clk) disable iff (rst)
    shiftCnt <= 8'(DATA_BITS));
endmodule

bind serial_byte_rx serial_byte_rx_chk #(.DATA_BITS(DATA_BITS)) chk (
  .clk(clk), .rst(rst), .dataOut(dataOut), .byteValid(byteValid),
  .frameError(frameError), .strobes(strobes)
);

// File: tb/serial_byte_rx_test.sv
module serial_byte_rx_test;
  localparam int CPB = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       serialIn = 1'b1;
  logic [7:0] dataOut;
  logic       byteValid;
  logic       frameError;

  int checks = 0;
  int fails  = 0;
  int validCount = 0;
  int errCount   = 0;
  int partialBad = 0;
  int pulseBad   = 0;
  logic [7:0] hist [0:63];
  logic [7:0] prevData = '0;
  logic       prevValid = 1'b0;
  logic       prevErr = 1'b0;

  always #10 clk = ~clk;

  serial_byte_rx #(.CLKS_PER_BIT(CPB), .DATA_BITS(8)) uut (
    .clk(clk), .rst(rst), .serialIn(serialIn), .dataOut(dataOut),
    .byteValid(byteValid), .frameError(frameError)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (byteValid) begin
        hist[validCount[5:0]] = dataOut;
        validCount++;
      end
      if (frameError) errCount++;
      if (dataOut !== prevData && !byteValid) partialBad++;
      if ((prevValid && byteValid) || (prevErr && frameError)) pulseBad++;
    end
    prevData  = dataOut;
    prevValid = byteValid;
    prevErr   = frameError;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic holdLine(input logic lvl, input int cycles);
    serialIn = lvl;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopBit, input int gapBits);
    holdLine(1'b0, CPB);
    for (int i = 0; i < 8; i++) holdLine(b[i], CPB);
    holdLine(stopBit, CPB);
    if (gapBits > 0) holdLine(1'b1, gapBits * CPB);
  endtask

  task automatic testReset;
    check("R1 dataOut", dataOut, 0);
    check("R1 byteValid", byteValid, 0);
    check("R1 frameError", frameError, 0);
  endtask

  task automatic testOrder;
    int v0;
    v0 = validCount;
    sendFrame(8'b1011_0110, 1'b1, 2);
    check("R7 one valid pulse", validCount - v0, 1);
    check("R2 order 10110110", dataOut, 8'hB6);
    sendFrame(8'h01, 1'b1, 1);
    check("R2 first bit to bit0", dataOut, 8'h01);
    sendFrame(8'h80, 1'b1, 1);
    check("R2 last bit to bit7", dataOut, 8'h80);
  endtask

  task automatic testStopNotShifted;
    sendFrame(8'h00, 1'b1, 1);
    check("R5 zero byte no stop shift", dataOut, 8'h00);
    sendFrame(8'hFF, 1'b1, 1);
    check("R5 all ones", dataOut, 8'hFF);
  endtask

  task automatic testGlitch;
    int v0, e0;
    v0 = validCount; e0 = errCount;
    holdLine(1'b0, 3);
    holdLine(1'b1, 3 * CPB);
    check("R4 glitch no valid", validCount - v0, 0);
    check("R4 glitch no error", errCount - e0, 0);
    check("R4 glitch data kept", dataOut, 8'hFF);
    sendFrame(8'h5A, 1'b1, 1);
    check("R4 frame after glitch", dataOut, 8'h5A);
  endtask

  task automatic testFraming;
    int v0, e0;
    v0 = validCount; e0 = errCount;
    sendFrame(8'h3C, 1'b0, 0);
    holdLine(1'b0, 4 * CPB);
    check("R8 one frame error", errCount - e0, 1);
    check("R8 no valid on bad stop", validCount - v0, 0);
    check("R8 data kept", dataOut, 8'h5A);
    check("R3 stuck low no restart", errCount - e0 + validCount - v0, 1);
    holdLine(1'b1, 2 * CPB);
    sendFrame(8'hC3, 1'b1, 1);
    check("R3 restart after idle", dataOut, 8'hC3);
  endtask

  task automatic testBackToBack;
    int v0;
    v0 = validCount;
    sendFrame(8'h12, 1'b1, 0);
    sendFrame(8'h34, 1'b1, 0);
    sendFrame(8'hE7, 1'b1, 2);
    check("R9 three frames", validCount - v0, 3);
    check("R9 first", hist[v0[5:0]], 8'h12);
    check("R9 second", hist[6'(v0 + 1)], 8'h34);
    check("R9 third", hist[6'(v0 + 2)], 8'hE7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testReset();
    holdLine(1'b1, 2 * CPB);
    testOrder();
    testStopNotShifted();
    testGlitch();
    testFraming();
    testBackToBack();
    check("R6 no partial update", partialBad, 0);
    check("R7 single cycle strobes", pulseBad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule